// File: doc/BRIEF.md
# Receive Descriptor Ring Writeback Engine

This block is the receive-side descriptor manager of a DMA Ethernet MAC. It owns a small local memory holding a ring of two-word descriptors. The first word of each descriptor holds the buffer address together with two flags in its low bits. The second word is the status word that the engine fills in. Software prepares the ring through a simple word-wide port. The engine then consumes frame bytes from a byte stream that carries a last marker, and emits one address/data write per byte into the buffer of the current descriptor.

When a buffer fills before the frame ends, the frame continues into the next descriptor. Each chunk's status word is written before the descriptor is handed back to software by setting its ownership bit. The ring pointer then advances, and after a descriptor flagged as the ring's last it returns to the loaded base.

If the descriptor waiting at the start of a frame is still owned by software, the whole frame is swallowed and a one-cycle overrun pulse is raised. If a continuation descriptor is still owned, the stream is stalled until software frees it.

Top module: `rxr_wb_engine`

## Requirements
- R1: After reset the stream is not accepted (s_ready low), no write and no overrun pulse is issued, every descriptor word reads zero, and the ring pointer sits at descriptor 0.
- R2: Address word encoding: bit 0 is ownership (1 = filled by hardware, 0 = free), bit 1 flags the last ring entry, and bits 31:2 hold the word-aligned buffer address. The k-th byte of a chunk is written at buffer address + k, in stream order, in the cycle it is accepted.
- R3: Status word encoding: bits 13:0 carry the length, bit 14 start-of-frame, bit 15 end-of-frame, and bits 31:16 are zero.
- R4: A frame no longer than BUF_BYTES occupies one descriptor, whose status has both frame flags set and the frame length.
- R5: A longer frame is split at BUF_BYTES boundaries. Only the first chunk has start-of-frame. Each non-final chunk records BUF_BYTES without end-of-frame. The final chunk has end-of-frame and the total frame length.
- R6: For every chunk the status word is written in the cycle before the ownership bit of the same descriptor is set. The buffer address and the ring-end flag are preserved.
- R7: After a descriptor is used, the pointer moves to the next index, modulo NDESC. After a descriptor with the ring-end flag it moves to the ring base instead. A queue-base load sets both the base and the pointer.
- R8: If the descriptor at the pointer is owned when a frame starts, every byte of the frame is accepted and discarded. No descriptor changes, the pointer stays put, and ovf_pulse is high for exactly one cycle.
- R9: If the next descriptor needed by a frame in progress is owned, s_ready stays low and nothing is written until software frees it. The frame then continues without losing bytes.
- R10: A new frame is only started while rx_en is high. With rx_en low, a waiting byte is not accepted and the ring is untouched.
- R11: A software write (sw_sel 0 = address word, 1 = status word) updates that descriptor word, and sw_rdata returns the addressed word combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_en | input | 1 | Receive enable, sampled at frame start |
| qbase_ld | input | 1 | Load ring base and pointer from qbase_idx |
| qbase_idx | input | PW | Ring base descriptor index |
| s_valid | input | 1 | Stream byte valid |
| s_data | input | 8 | Stream byte |
| s_last | input | 1 | Last byte of the frame |
| s_ready | output | 1 | Stream byte accepted this cycle |
| wr_valid | output | 1 | Buffer byte write strobe |
| wr_addr | output | 32 | Buffer byte address |
| wr_data | output | 8 | Buffer byte data |
| sw_we | input | 1 | Software descriptor write |
| sw_idx | input | PW | Software descriptor index |
| sw_sel | input | 1 | Word select: 0 address word, 1 status word |
| sw_wdata | input | 32 | Software write data |
| sw_rdata | output | 32 | Addressed descriptor word |
| ovf_pulse | output | 1 | One-cycle pulse when a frame is dropped |

## Verification
The hardest condition to reach is a stall in the middle of a frame. It needs the continuation descriptor to be one that the same frame already filled. The bench reaches it by loading a base of 1 and flagging descriptor 2 as the ring end, which gives a two-entry ring. It then sends a frame of more than two buffers with 4-byte buffers. While the engine is stalled, the bench checks the stall and the first chunk's status. It then frees that descriptor and lets the frame finish into it. Because the ring is left full afterwards, the next frame lands on an owned descriptor and is dropped.

// File: rtl/rxr_pkg.sv
package rxr_pkg;
    // Address word flag positions
    localparam int unsigned OWN_BIT  = 0;
    localparam int unsigned WRAP_BIT = 1;
    // Status word layout
    localparam int unsigned LEN_W    = 14;
    localparam int unsigned SOF_BIT  = 14;
    localparam int unsigned EOF_BIT  = 15;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FILL,
        ST_STAT,
        ST_MARK,
        ST_WAIT,
        ST_DROP
    } rx_state_e;
endpackage

// File: rtl/rxr_ptr_adv.sv
module rxr_ptr_adv #(
    parameter int NDESC = 32,
    localparam int PW = (NDESC > 1) ? $clog2(NDESC) : 1
) (
    input  logic [PW-1:0] ptr,
    input  logic [PW-1:0] base,
    input  logic          wrap,
    output logic [PW-1:0] nxt
);
    logic [PW-1:0] inc;

    generate
        if (NDESC > 1 && (NDESC & (NDESC - 1)) == 0) begin : g_pow2
            assign inc = ptr + PW'(1);
        end else begin : g_cmp
            assign inc = (ptr == PW'(NDESC - 1)) ? '0 : ptr + PW'(1);
        end
    endgenerate

    assign nxt = wrap ? base : inc;
endmodule

// File: rtl/rxr_desc_mem.sv
module rxr_desc_mem #(
    parameter int NDESC = 32,
    localparam int PW    = (NDESC > 1) ? $clog2(NDESC) : 1,
    localparam int DEPTH = 2 * NDESC
) (
    input  logic          clk,
    input  logic          rst_n,
    // engine side: address word read at pointer, single write port
    input  logic [PW-1:0] eng_ridx,
    output logic [31:0]   eng_rword0,
    input  logic          eng_we,
    input  logic [PW-1:0] eng_idx,
    input  logic          eng_sel,
    input  logic [31:0]   eng_wdata,
    // software side
    input  logic          sw_we,
    input  logic [PW-1:0] sw_idx,
    input  logic          sw_sel,
    input  logic [31:0]   sw_wdata,
    output logic [31:0]   sw_rdata
);
    logic [31:0] mem_q [DEPTH];

    assign eng_rword0 = mem_q[{eng_ridx, 1'b0}];
    assign sw_rdata   = mem_q[{sw_idx, sw_sel}];

    // engine write placed last so it wins on a same-word collision
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else begin
            if (sw_we)  mem_q[{sw_idx, sw_sel}]   <= sw_wdata;
            if (eng_we) mem_q[{eng_idx, eng_sel}] <= eng_wdata;
        end
    end
endmodule

// File: rtl/rxr_ctrl.sv
module rxr_ctrl
    import rxr_pkg::*;
#(
    parameter int NDESC     = 32,
    parameter int BUF_BYTES = 1536,
    localparam int PW = (NDESC > 1) ? $clog2(NDESC) : 1,
    localparam int CW = $clog2(BUF_BYTES + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rx_en,
    input  logic          qbase_ld,
    input  logic [PW-1:0] qbase_idx,
    input  logic          s_valid,
    input  logic          s_last,
    output logic          s_ready,
    output logic          wr_valid,
    output logic [31:0]   wr_addr,
    input  logic [31:0]   desc_w0,
    output logic [PW-1:0] ptr,
    output logic          eng_we,
    output logic          eng_sel,
    output logic [31:0]   eng_wdata,
    output logic          ovf
);
    typedef struct packed {
        rx_state_e        st;
        logic [PW-1:0]    ptr;
        logic [PW-1:0]    base;
        logic [CW-1:0]    cnt;
        logic [LEN_W-1:0] tot;
        logic             sof;
        logic             eof;
        logic             ovf;
    } ctl_t;

    ctl_t q, d;
    logic [PW-1:0]    ptr_nx;
    logic [LEN_W-1:0] st_len;

    rxr_ptr_adv #(.NDESC(NDESC)) u_adv (
        .ptr  (q.ptr),
        .base (q.base),
        .wrap (desc_w0[WRAP_BIT]),
        .nxt  (ptr_nx)
    );

    assign st_len = q.eof ? q.tot : LEN_W'(BUF_BYTES);

    always_comb begin
        d         = q;
        d.ovf     = 1'b0;
        s_ready   = 1'b0;
        wr_valid  = 1'b0;
        eng_we    = 1'b0;
        eng_sel   = 1'b0;
        eng_wdata = '0;
        unique case (q.st)
            ST_IDLE: begin
                if (rx_en && s_valid) begin
                    if (desc_w0[OWN_BIT]) begin
                        d.st  = ST_DROP;
                        d.ovf = 1'b1;
                    end else begin
                        d.st  = ST_FILL;
                        d.sof = 1'b1;
                        d.eof = 1'b0;
                        d.cnt = '0;
                        d.tot = '0;
                    end
                end
            end
            ST_FILL: begin
                s_ready = 1'b1;
                if (s_valid) begin
                    wr_valid = 1'b1;
                    d.cnt    = q.cnt + CW'(1);
                    d.tot    = q.tot + LEN_W'(1);
                    if (s_last) begin
                        d.eof = 1'b1;
                        d.st  = ST_STAT;
                    end else if (q.cnt == CW'(BUF_BYTES - 1)) begin
                        d.st  = ST_STAT;
                    end
                end
            end
            ST_STAT: begin
                eng_we                 = 1'b1;
                eng_sel                = 1'b1;
                eng_wdata[LEN_W-1:0]   = st_len;
                eng_wdata[SOF_BIT]     = q.sof;
                eng_wdata[EOF_BIT]     = q.eof;
                d.st                   = ST_MARK;
            end
            ST_MARK: begin
                eng_we             = 1'b1;
                eng_sel            = 1'b0;
                eng_wdata          = desc_w0;
                eng_wdata[OWN_BIT] = 1'b1;
                d.ptr              = ptr_nx;
                d.sof              = 1'b0;
                d.st               = q.eof ? ST_IDLE : ST_WAIT;
            end
            ST_WAIT: begin
                if (!desc_w0[OWN_BIT]) begin
                    d.st  = ST_FILL;
                    d.cnt = '0;
                end
            end
            ST_DROP: begin
                s_ready = 1'b1;
                if (s_valid && s_last) d.st = ST_IDLE;
            end
            default: d.st = ST_IDLE;
        endcase
        if (qbase_ld) begin
            d.base = qbase_idx;
            d.ptr  = qbase_idx;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: ST_IDLE, ptr: '0, base: '0, cnt: '0, tot: '0,
                   sof: 1'b0, eof: 1'b0, ovf: 1'b0};
        end else begin
            q <= d;
        end
    end

    assign wr_addr = {desc_w0[31:2], 2'b00} + 32'(q.cnt);
    assign ptr     = q.ptr;
    assign ovf     = q.ovf;
endmodule

// File: rtl/rxr_wb_engine.sv
module rxr_wb_engine #(
    parameter int NDESC     = 32,
    parameter int BUF_BYTES = 1536,
    localparam int PW = (NDESC > 1) ? $clog2(NDESC) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rx_en,
    input  logic          qbase_ld,
    input  logic [PW-1:0] qbase_idx,
    input  logic          s_valid,
    input  logic [7:0]    s_data,
    input  logic          s_last,
    output logic          s_ready,
    output logic          wr_valid,
    output logic [31:0]   wr_addr,
    output logic [7:0]    wr_data,
    input  logic          sw_we,
    input  logic [PW-1:0] sw_idx,
    input  logic          sw_sel,
    input  logic [31:0]   sw_wdata,
    output logic [31:0]   sw_rdata,
    output logic          ovf_pulse
);
    logic [31:0]   desc_w0;
    logic [PW-1:0] ptr;
    logic          eng_we;
    logic          eng_sel;
    logic [31:0]   eng_wdata;

    rxr_desc_mem #(.NDESC(NDESC)) u_mem (
        .clk        (clk),
        .rst_n      (rst_n),
        .eng_ridx   (ptr),
        .eng_rword0 (desc_w0),
        .eng_we     (eng_we),
        .eng_idx    (ptr),
        .eng_sel    (eng_sel),
        .eng_wdata  (eng_wdata),
        .sw_we      (sw_we),
        .sw_idx     (sw_idx),
        .sw_sel     (sw_sel),
        .sw_wdata   (sw_wdata),
        .sw_rdata   (sw_rdata)
    );

    rxr_ctrl #(.NDESC(NDESC), .BUF_BYTES(BUF_BYTES)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .rx_en     (rx_en),
        .qbase_ld  (qbase_ld),
        .qbase_idx (qbase_idx),
        .s_valid   (s_valid),
        .s_last    (s_last),
        .s_ready   (s_ready),
        .wr_valid  (wr_valid),
        .wr_addr   (wr_addr),
        .desc_w0   (desc_w0),
        .ptr       (ptr),
        .eng_we    (eng_we),
        .eng_sel   (eng_sel),
        .eng_wdata (eng_wdata),
        .ovf       (ovf_pulse)
    );

    assign wr_data = s_data;
endmodule

// File: rtl/rxr_wb_chk.sv
module rxr_wb_chk #(
    parameter int NDESC = 32,
    localparam int PW = (NDESC > 1) ? $clog2(NDESC) : 1
) (
    input logic          clk,
    input logic          rst_n,
    input logic          s_valid,
    input logic          s_ready,
    input logic          wr_valid,
    input logic          ovf_pulse,
    input logic          eng_we,
    input logic          eng_sel,
    input logic [PW-1:0] ptr,
    input logic [31:0]   desc_w0
);
    AST_STATUS_BEFORE_OWN: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_we && !eng_sel) |-> ($past(eng_we && eng_sel) && $stable(ptr))); // R6

    AST_NO_STATUS_ON_OWNED: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_we && eng_sel) |-> !desc_w0[0]); // R8

    AST_WRITE_NEEDS_HANDSHAKE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> (s_valid && s_ready)); // R2

    AST_FILL_ONLY_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> !desc_w0[0]); // R9

    AST_OVF_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_pulse |=> !ovf_pulse); // R8

    AST_PTR_IN_RING: assert property (@(posedge clk) disable iff (!rst_n)
        32'(ptr) < NDESC); // R7
endmodule

bind rxr_wb_engine rxr_wb_chk #(.NDESC(NDESC)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .s_valid   (s_valid),
    .s_ready   (s_ready),
    .wr_valid  (wr_valid),
    .ovf_pulse (ovf_pulse),
    .eng_we    (eng_we),
    .eng_sel   (eng_sel),
    .ptr       (ptr),
    .desc_w0   (desc_w0)
);

// File: tb/sim_rxr_wb_engine.sv
`timescale 1ns/1ps
module sim_rxr_wb_engine;
    localparam int N  = 4;
    localparam int B  = 4;
    localparam int PW = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          rx_en = 1'b0;
    logic          qbase_ld = 1'b0;
    logic [PW-1:0] qbase_idx = '0;
    logic          s_valid = 1'b0;
    logic [7:0]    s_data = '0;
    logic          s_last = 1'b0;
    logic          s_ready;
    logic          wr_valid;
    logic [31:0]   wr_addr;
    logic [7:0]    wr_data;
    logic          sw_we = 1'b0;
    logic [PW-1:0] sw_idx = '0;
    logic          sw_sel = 1'b0;
    logic [31:0]   sw_wdata = '0;
    logic [31:0]   sw_rdata;
    logic          ovf_pulse;

    int n_chk = 0;
    int n_fail = 0;
    int ovf_cnt = 0;
    bit done = 0;

    // ring model
    bit wrapb [N];
    int exp_base, exp_idx, exp_off, exp_tot, nch;
    int cidx [8];
    int clen [8];
    bit csof [8];
    bit ceof [8];

    always #2 clk = ~clk;

    rxr_wb_engine #(.NDESC(N), .BUF_BYTES(B)) u0 (
        .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .qbase_ld(qbase_ld),
        .qbase_idx(qbase_idx), .s_valid(s_valid), .s_data(s_data),
        .s_last(s_last), .s_ready(s_ready), .wr_valid(wr_valid),
        .wr_addr(wr_addr), .wr_data(wr_data), .sw_we(sw_we), .sw_idx(sw_idx),
        .sw_sel(sw_sel), .sw_wdata(sw_wdata), .sw_rdata(sw_rdata),
        .ovf_pulse(ovf_pulse)
    );

    always @(negedge clk) if (rst_n && ovf_pulse) ovf_cnt++;

    function automatic logic [31:0] baddr(input int i);
        return 32'h0000_1000 + 32'(i) * 32'h100;
    endfunction

    function automatic logic [31:0] w0(input int i);
        return baddr(i) | (wrapb[i] ? 32'h2 : 32'h0);
    endfunction

    function automatic logic [31:0] stw(input int c);
        return {16'h0, ceof[c], csof[c], 14'(clen[c])};
    endfunction

    task automatic chk_eq(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic sw_write(input int i, input bit s, input logic [31:0] v);
        @(negedge clk);
        sw_we = 1'b1; sw_idx = PW'(i); sw_sel = s; sw_wdata = v;
        @(negedge clk);
        sw_we = 1'b0;
    endtask

    task automatic sw_read(input int i, input bit s, output logic [31:0] v);
        @(negedge clk);
        sw_idx = PW'(i); sw_sel = s;
        #1 v = sw_rdata;
    endtask

    task automatic start_frame();
        nch = 0; exp_off = 0; exp_tot = 0;
    endtask

    task automatic send_byte(input logic [7:0] dv, input bit lst, input bit drop);
        bit r;
        @(negedge clk);
        s_valid = 1'b1; s_data = dv; s_last = lst;
        forever begin
            #1 r = s_ready;
            if (r) begin
                if (drop) begin
                    chk_eq("R8 dropped byte not written", 32'(wr_valid), 32'd0);
                end else begin
                    chk_eq("R2 write strobe", 32'(wr_valid), 32'd1);
                    chk_eq("R2 write address", wr_addr, baddr(exp_idx) + 32'(exp_off));
                    chk_eq("R2 write data", 32'(wr_data), 32'(dv));
                    exp_off++; exp_tot++;
                    if (exp_off == B || lst) begin
                        cidx[nch] = exp_idx;
                        clen[nch] = lst ? exp_tot : B;
                        csof[nch] = (nch == 0);
                        ceof[nch] = lst;
                        nch++;
                        exp_idx = wrapb[exp_idx] ? exp_base : (exp_idx + 1) % N;
                        exp_off = 0;
                    end
                end
            end
            @(posedge clk);
            if (r) break;
            @(negedge clk);
        end
        #1 s_valid = 1'b0; s_last = 1'b0;
    endtask

    task automatic send_frame(input int len);
        start_frame();
        for (int k = 0; k < len; k++) send_byte(8'(k * 7 + len), k == len - 1, 1'b0);
    endtask

    // check chunks from..nch-1: status (R3/R4/R5) and ownership (R6); optionally free
    task automatic verify(input int from, input bit fr);
        logic [31:0] v;
        repeat (4) @(negedge clk);
        for (int c = from; c < nch; c++) begin
            sw_read(cidx[c], 1'b1, v);
            chk_eq(nch == 1 ? "R4 single-buffer status" : "R3 R5 chunk status", v, stw(c));
            sw_read(cidx[c], 1'b0, v);
            chk_eq("R6 owned with address kept", v, w0(cidx[c]) | 32'h1);
            if (fr) sw_write(cidx[c], 1'b0, w0(cidx[c]));
        end
    endtask

    initial begin
        logic [31:0] v;
        int ovf_base;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        chk_eq("R1 s_ready after reset", 32'(s_ready), 32'd0);
        chk_eq("R1 wr_valid after reset", 32'(wr_valid), 32'd0);
        chk_eq("R1 ovf after reset", 32'(ovf_pulse), 32'd0);
        for (int i = 0; i < N; i++) begin
            sw_read(i, 1'b0, v); chk_eq("R1 address word cleared", v, 32'd0);
            sw_read(i, 1'b1, v); chk_eq("R1 status word cleared", v, 32'd0);
        end

        // ring of four, end flag on entry 3, pointer left at reset value 0
        for (int i = 0; i < N; i++) begin
            wrapb[i] = (i == N - 1);
            sw_write(i, 1'b0, w0(i));
            sw_read(i, 1'b0, v);
            chk_eq("R11 software write readback", v, w0(i));
        end
        exp_base = 0; exp_idx = 0;
        rx_en = 1'b1;
        for (int len = 1; len <= 10; len++) begin
            send_frame(len);
            verify(0, 1'b1);
        end

        // R7: two-entry ring (base 1, end flag on 2) forcing a mid-frame stall
        for (int i = 0; i < N; i++) begin
            wrapb[i] = (i == 2);
            sw_write(i, 1'b0, w0(i));
        end
        @(negedge clk); qbase_idx = 2'd1; qbase_ld = 1'b1;
        @(negedge clk); qbase_ld = 1'b0;
        exp_base = 1; exp_idx = 1;
        start_frame();
        for (int k = 0; k < 8; k++) send_byte(8'(8'h40 + k), 1'b0, 1'b0);
        @(negedge clk);
        s_valid = 1'b1; s_data = 8'h48; s_last = 1'b1;
        repeat (8) @(negedge clk);
        #1;
        chk_eq("R9 stalled ready", 32'(s_ready), 32'd0);
        chk_eq("R9 stalled no write", 32'(wr_valid), 32'd0);
        verify(0, 1'b0);
        sw_write(1, 1'b0, w0(1));
        send_byte(8'h48, 1'b1, 1'b0);
        chk_eq("R9 continuation into freed entry", 32'(cidx[2]), 32'd1);
        verify(2, 1'b0);

        // R8: pointer at entry 2, which is still owned
        ovf_base = ovf_cnt;
        send_byte(8'h11, 1'b0, 1'b1);
        send_byte(8'h22, 1'b0, 1'b1);
        send_byte(8'h33, 1'b1, 1'b1);
        repeat (3) @(negedge clk);
        chk_eq("R8 single overrun pulse", 32'(ovf_cnt - ovf_base), 32'd1);
        sw_read(2, 1'b1, v);
        chk_eq("R8 owned descriptor untouched", v, stw(1));
        sw_write(1, 1'b0, w0(1));
        sw_write(2, 1'b0, w0(2));
        send_frame(2);
        chk_eq("R8 pointer unchanged by drop", 32'(cidx[0]), 32'd2);
        verify(0, 1'b1);
        chk_eq("R7 return to base after end flag", 32'(exp_idx), 32'd1);

        // R10: no frame start while disabled
        rx_en = 1'b0;
        @(negedge clk);
        s_valid = 1'b1; s_data = 8'hAA; s_last = 1'b1;
        repeat (6) @(negedge clk);
        #1;
        chk_eq("R10 disabled ready", 32'(s_ready), 32'd0);
        chk_eq("R10 disabled no write", 32'(wr_valid), 32'd0);
        sw_read(1, 1'b0, v);
        chk_eq("R10 descriptor stays free", v, w0(1));
        rx_en = 1'b1;
        start_frame();
        send_byte(8'hAA, 1'b1, 1'b0);
        verify(0, 1'b1);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule